// File: doc/BRIEF.md
# Serial Channel Status Flag Tracker

This block holds the read-only status byte of one channel of a serial interface unit. It follows the channel through its life: whether a transfer is running, whether the single data buffer currently holds valid data, and which receive or buffer errors have been seen since software last acknowledged them. Its inputs are single-cycle event strobes from the channel engine (start, stop command, suspend command, end of transfer, buffer-to-shifter load, receive store, framing and parity error), bus strobes for buffer writes and reads, the transmit-enable and receive-enable mode bits, and one acknowledge strobe per error flag.

Each flag has its own set and clear events with a fixed priority. A bus write to a buffer that still holds valid data raises the overrun flag and sends a one-cycle discard pulse to the buffer logic so it drops the old contents. A parameter decides whether the channel carries a framing-error flag; without it that status bit reads as zero. All flags update on the clock edge after their event and appear on the status byte in that same cycle.

Top module: `serial_status_tracker`

## Requirements
- R1: Status bit 6 is transfer-active, bit 5 is buffer-valid, bit 2 is framing error, bit 1 is parity error, bit 0 is overrun; bits 7, 4 and 3 always read 0.
- R2: With HAS_FRAME_ERR = 0, status bit 2 always reads 0, even after a framing-error strobe with receive enabled.
- R3: While reset is asserted and on the first cycle after it, the status byte is 0x00 and the discard pulse is 0.
- R4: Transfer-active becomes 1 the cycle after a start strobe and becomes 0 the cycle after an end-of-transfer strobe, a stop command or a suspend command.
- R5: When events coincide, a stop or suspend command clears transfer-active and buffer-valid regardless of anything else; otherwise a start strobe beats end-of-transfer, and any buffer-valid set event beats a load or read clear.
- R6: Buffer-valid sets after a bus write while transmit is enabled, a receive store while receive is enabled, or a framing or parity strobe while receive is enabled; it clears after a buffer-to-shifter load, a bus read, a stop or a suspend.
- R7: A bus write while buffer-valid is 1 sets the overrun flag in the next cycle, and the discard output is 1 in exactly that next cycle; a write with buffer-valid 0 raises neither, whatever transmit-enable is.
- R8: The framing and parity flags set the cycle after their error strobe only while receive-enable is 1; a strobe with receive-enable 0 changes neither flag nor buffer-valid.
- R9: Error flags are sticky: each clears only on its own acknowledge strobe, a set event in the same cycle as its acknowledge leaves it at 1, and stop or suspend commands leave all error flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_start | input | 1 | Transfer starts |
| cmd_stop | input | 1 | Stop command |
| cmd_suspend | input | 1 | Suspend command |
| evt_done | input | 1 | Transfer has ended |
| evt_load | input | 1 | Buffer content moved into the shifter |
| evt_rx_store | input | 1 | Received data written into the buffer |
| rx_frame_err | input | 1 | Framing error seen by the receiver |
| rx_parity_err | input | 1 | Parity error seen by the receiver |
| bus_wr | input | 1 | Bus writes the buffer |
| bus_rd | input | 1 | Bus has finished reading the buffer |
| tx_en | input | 1 | Transmit enabled mode bit |
| rx_en | input | 1 | Receive enabled mode bit |
| ack_frame | input | 1 | Clear framing-error flag |
| ack_parity | input | 1 | Clear parity-error flag |
| ack_overrun | input | 1 | Clear overrun flag |
| status | output | 8 | Status byte |
| discard | output | 1 | One-cycle pulse: held buffer data is to be dropped |

## Verification
A wrong flag register shows on the status byte one cycle after the event that should have moved it, since every bit is a direct register output, so a cycle-by-cycle comparison against a bench model locates the faulty event and priority at once. A lost overrun additionally shows as a missing discard pulse in the same cycle, and a buffer-valid flag stuck high surfaces later as spurious overruns on the next write. Coincident events and the absent-framing variant are the cases where a priority or a generate choice error would otherwise hide.

// File: rtl/sst_pkg.sv
package sst_pkg;
   localparam int unsigned STATUS_W  = 8;
   localparam int unsigned BIT_ACT   = 6;
   localparam int unsigned BIT_BUFV  = 5;
   localparam int unsigned BIT_FRAME = 2;
   localparam int unsigned BIT_PAR   = 1;
   localparam int unsigned BIT_OVR   = 0;
   localparam int unsigned N_ERR     = 3;

   typedef enum logic [1:0] {
      UPD_HOLD = 2'd0,
      UPD_SET  = 2'd1,
      UPD_CLR  = 2'd2
   } upd_t;

   // kill beats set, set beats a normal clear
   function automatic upd_t flag_decide(input logic kill, input logic set_i, input logic clr_i);
      if (kill)       return UPD_CLR;
      else if (set_i) return UPD_SET;
      else if (clr_i) return UPD_CLR;
      else            return UPD_HOLD;
   endfunction
endpackage

// File: rtl/sst_flag_cell.sv
module sst_flag_cell
   import sst_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic kill,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_q
);
   upd_t act;

   always_comb act = flag_decide(kill, set_i, clr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else begin
         case (act)
            UPD_SET: flag_q <= 1'b1;
            UPD_CLR: flag_q <= 1'b0;
            default: flag_q <= flag_q;
         endcase
      end
   end
endmodule

// File: rtl/sst_err_bank.sv
module sst_err_bank #(
   parameter int unsigned N_FLAGS = 3,
   parameter logic [N_FLAGS-1:0] PRESENT = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_FLAGS-1:0] set_vec,
   input  logic [N_FLAGS-1:0] ack_vec,
   output logic [N_FLAGS-1:0] flags_q
);
   if (N_FLAGS < 1) begin : g_bad_n
      $error("sst_err_bank: N_FLAGS must be at least 1");
   end

   for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
      if (PRESENT[i]) begin : g_reg
         // sticky: set wins over acknowledge in the same cycle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flags_q[i] <= 1'b0;
            else if (set_vec[i]) flags_q[i] <= 1'b1;
            else if (ack_vec[i]) flags_q[i] <= 1'b0;
         end
      end else begin : g_tie
         assign flags_q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/serial_status_tracker.sv
module serial_status_tracker
   import sst_pkg::*;
#(
   parameter int unsigned HAS_FRAME_ERR = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                evt_start,
   input  logic                cmd_stop,
   input  logic                cmd_suspend,
   input  logic                evt_done,
   input  logic                evt_load,
   input  logic                evt_rx_store,
   input  logic                rx_frame_err,
   input  logic                rx_parity_err,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic                tx_en,
   input  logic                rx_en,
   input  logic                ack_frame,
   input  logic                ack_parity,
   input  logic                ack_overrun,
   output logic [STATUS_W-1:0] status,
   output logic                discard
);
   localparam logic [N_ERR-1:0] ERR_PRESENT = {(HAS_FRAME_ERR != 0), 1'b1, 1'b1};

   if (HAS_FRAME_ERR > 1) begin : g_bad_opt
      $error("serial_status_tracker: HAS_FRAME_ERR must be 0 or 1");
   end
   if (BIT_ACT >= STATUS_W || BIT_BUFV >= STATUS_W || BIT_FRAME >= STATUS_W) begin : g_bad_map
      $error("serial_status_tracker: status bit map exceeds status width");
   end

   logic             kill;
   logic             rx_err_ev;
   logic             bufv_set;
   logic             bufv_clr;
   logic             act_q;
   logic             bufv_q;
   logic             ovr_hit;
   logic             discard_q;
   logic [N_ERR-1:0] err_set;
   logic [N_ERR-1:0] err_ack;
   logic [N_ERR-1:0] err_q;

   always_comb begin
      kill      = cmd_stop | cmd_suspend;
      rx_err_ev = rx_en & (rx_frame_err | rx_parity_err);
      bufv_set  = (bus_wr & tx_en) | (evt_rx_store & rx_en) | rx_err_ev;
      bufv_clr  = evt_load | bus_rd;
      ovr_hit   = bus_wr & bufv_q;
   end

   sst_flag_cell u_act (
      .clk    (clk),
      .rst_n  (rst_n),
      .kill   (kill),
      .set_i  (evt_start),
      .clr_i  (evt_done),
      .flag_q (act_q)
   );

   sst_flag_cell u_bufv (
      .clk    (clk),
      .rst_n  (rst_n),
      .kill   (kill),
      .set_i  (bufv_set),
      .clr_i  (bufv_clr),
      .flag_q (bufv_q)
   );

   always_comb begin
      err_set            = '0;
      err_ack            = '0;
      err_set[BIT_FRAME] = rx_en & rx_frame_err;
      err_set[BIT_PAR]   = rx_en & rx_parity_err;
      err_set[BIT_OVR]   = ovr_hit;
      err_ack[BIT_FRAME] = ack_frame;
      err_ack[BIT_PAR]   = ack_parity;
      err_ack[BIT_OVR]   = ack_overrun;
   end

   sst_err_bank #(
      .N_FLAGS (N_ERR),
      .PRESENT (ERR_PRESENT)
   ) u_err (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (err_set),
      .ack_vec (err_ack),
      .flags_q (err_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) discard_q <= 1'b0;
      else        discard_q <= ovr_hit;
   end

   always_comb begin
      status           = '0;
      status[BIT_ACT]  = act_q;
      status[BIT_BUFV] = bufv_q;
      for (int k = 0; k < N_ERR; k++) status[k] = err_q[k];
   end

   assign discard = discard_q;
endmodule

// File: rtl/sst_chk.sv
module sst_chk #(
   parameter int unsigned HAS_FRAME_ERR = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       evt_start,
   input logic       cmd_stop,
   input logic       cmd_suspend,
   input logic       rx_parity_err,
   input logic       rx_frame_err,
   input logic       bus_wr,
   input logic       rx_en,
   input logic       ack_parity,
   input logic [7:0] status,
   input logic       discard
);
   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (status[7] == 1'b0 && status[4] == 1'b0 && status[3] == 1'b0)); // R1

   AST_NO_FRAME_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_FRAME_ERR == 0) |-> (status[2] == 1'b0)); // R2

   AST_START_SETS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_start && !cmd_stop && !cmd_suspend) |=> status[6]); // R4

   AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stop || cmd_suspend) |=> (!status[6] && !status[5])); // R5

   AST_OVERRUN_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && status[5]) |=> (status[0] && discard)); // R7

   AST_DISCARD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!(bus_wr && status[5])) |=> !discard); // R7

   AST_PARITY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!status[1] && !(rx_parity_err && rx_en)) |=> !status[1]); // R8

   AST_PARITY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (status[1] && !ack_parity) |=> status[1]); // R9

   AST_FRAME_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!status[2] && !(rx_frame_err && rx_en)) |=> !status[2]); // R8
endmodule

bind serial_status_tracker sst_chk #(.HAS_FRAME_ERR(HAS_FRAME_ERR)) u_sst_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .evt_start     (evt_start),
   .cmd_stop      (cmd_stop),
   .cmd_suspend   (cmd_suspend),
   .rx_parity_err (rx_parity_err),
   .rx_frame_err  (rx_frame_err),
   .bus_wr        (bus_wr),
   .rx_en         (rx_en),
   .ack_parity    (ack_parity),
   .status        (status),
   .discard       (discard)
);

// File: tb/test_serial_status_tracker.sv
`timescale 1ns/1ps
module test_serial_status_tracker;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic evt_start = 0, cmd_stop = 0, cmd_suspend = 0, evt_done = 0, evt_load = 0;
   logic evt_rx_store = 0, rx_frame_err = 0, rx_parity_err = 0, bus_wr = 0, bus_rd = 0;
   logic tx_en = 0, rx_en = 0, ack_frame = 0, ack_parity = 0, ack_overrun = 0;
   logic [7:0] status, status_nf;
   logic discard, discard_nf;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // bench model state
   logic m_act = 0, m_bufv = 0, m_fe = 0, m_pe = 0, m_ov = 0, m_dis = 0;

   always #2 clk = ~clk;

   serial_status_tracker #(.HAS_FRAME_ERR(1)) i_serial_status_tracker (
      .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .cmd_stop(cmd_stop),
      .cmd_suspend(cmd_suspend), .evt_done(evt_done), .evt_load(evt_load),
      .evt_rx_store(evt_rx_store), .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .tx_en(tx_en), .rx_en(rx_en),
      .ack_frame(ack_frame), .ack_parity(ack_parity), .ack_overrun(ack_overrun),
      .status(status), .discard(discard));

   serial_status_tracker #(.HAS_FRAME_ERR(0)) i_serial_status_tracker_nf (
      .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .cmd_stop(cmd_stop),
      .cmd_suspend(cmd_suspend), .evt_done(evt_done), .evt_load(evt_load),
      .evt_rx_store(evt_rx_store), .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .tx_en(tx_en), .rx_en(rx_en),
      .ack_frame(ack_frame), .ack_parity(ack_parity), .ack_overrun(ack_overrun),
      .status(status_nf), .discard(discard_nf));

   function automatic logic [7:0] exp_status(input bit with_frame);
      return {1'b0, m_act, m_bufv, 2'b00, m_fe & with_frame, m_pe, m_ov};
   endfunction

   function automatic string bit_tag(input int b, input bit nf);
      case (b)
         6: return "R4";
         5: return "R6";
         2: return nf ? "R2" : "R8";
         1: return "R8";
         0: return "R7";
         default: return "R1";
      endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // model update from the inputs present at the clock edge
   task automatic model_step();
      logic kill, rxe, bset, bclr, ovh;
      kill = cmd_stop | cmd_suspend;
      rxe  = rx_en & (rx_frame_err | rx_parity_err);
      bset = (bus_wr & tx_en) | (evt_rx_store & rx_en) | rxe;
      bclr = evt_load | bus_rd;
      ovh  = bus_wr & m_bufv;
      m_act  = kill ? 1'b0 : evt_start ? 1'b1 : evt_done ? 1'b0 : m_act;
      m_bufv = kill ? 1'b0 : bset ? 1'b1 : bclr ? 1'b0 : m_bufv;
      m_fe   = (rx_en & rx_frame_err) ? 1'b1 : ack_frame ? 1'b0 : m_fe;
      m_pe   = (rx_en & rx_parity_err) ? 1'b1 : ack_parity ? 1'b0 : m_pe;
      m_ov   = ovh ? 1'b1 : ack_overrun ? 1'b0 : m_ov;
      m_dis  = ovh;
   endtask

   task automatic compare_all();
      logic [7:0] e1, e0;
      e1 = exp_status(1'b1);
      e0 = exp_status(1'b0);
      for (int b = 0; b < 8; b++) begin
         chk(bit_tag(b, 1'b0), status[b], e1[b]);
         chk(bit_tag(b, 1'b1), status_nf[b], e0[b]);
      end
      chk("R7", discard, m_dis);
      chk("R7", discard_nf, m_dis);
   endtask

   task automatic quiet();
      evt_start = 0; cmd_stop = 0; cmd_suspend = 0; evt_done = 0; evt_load = 0;
      evt_rx_store = 0; rx_frame_err = 0; rx_parity_err = 0; bus_wr = 0; bus_rd = 0;
      ack_frame = 0; ack_parity = 0; ack_overrun = 0;
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
      quiet();
   endtask

   function automatic logic rnd(input int unsigned den);
      return ($urandom_range(den - 1, 0) == 0);
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      quiet();
      repeat (3) @(negedge clk);
      chk("R3", status, 8'h00);
      chk("R3", discard, 0);
      chk("R3", status_nf, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R3", status, 8'h00);

      // R5: stop beats start
      evt_start = 1; cmd_stop = 1; tick();
      chk("R5", status[6], 0);
      // R5: start beats done
      evt_start = 1; evt_done = 1; tick();
      chk("R5", status[6], 1);
      // R4: suspend clears transfer-active
      cmd_suspend = 1; tick();
      chk("R4", status[6], 0);

      // R7: write with buffer empty and tx disabled: no overrun, no buffer-valid
      tx_en = 0; bus_wr = 1; tick();
      chk("R7", status[0], 0);
      chk("R6", status[5], 0);
      // R6: write with tx enabled sets buffer-valid
      tx_en = 1; bus_wr = 1; tick();
      chk("R6", status[5], 1);
      chk("R7", discard, 0);
      // R7: write to full buffer raises overrun and discard for one cycle
      bus_wr = 1; tick();
      chk("R7", status[0], 1);
      chk("R7", discard, 1);
      tick();
      chk("R7", discard, 0);
      // R9: stop clears buffer-valid but keeps overrun
      cmd_stop = 1; tick();
      chk("R6", status[5], 0);
      chk("R9", status[0], 1);
      // R5: set beats load clear
      bus_wr = 1; evt_load = 1; tick();
      chk("R5", status[5], 1);
      evt_load = 1; tick();
      chk("R6", status[5], 0);

      // R8: parity strobe ignored with rx disabled
      rx_en = 0; rx_parity_err = 1; rx_frame_err = 1; tick();
      chk("R8", status[2:0], 3'b001);
      chk("R8", status[5], 0);
      // R8: with rx enabled both flags and buffer-valid set
      rx_en = 1; rx_parity_err = 1; rx_frame_err = 1; tick();
      chk("R8", status[2:1], 2'b11);
      chk("R6", status[5], 1);
      chk("R2", status_nf[2], 0);
      // R9: acknowledge with coincident set keeps the flag
      ack_parity = 1; rx_parity_err = 1; tick();
      chk("R9", status[1], 1);
      ack_parity = 1; ack_overrun = 1; cmd_suspend = 1; tick();
      chk("R9", status[2:0], 3'b100);
      ack_frame = 1; tick();
      chk("R9", status[2], 0);
      chk("R1", {status[7], status[4], status[3]}, 3'b000);

      // constrained random phase
      for (int i = 0; i < 4000; i++) begin
         if (rnd(16)) tx_en = ~tx_en;
         if (rnd(16)) rx_en = ~rx_en;
         evt_start     = rnd(6);
         evt_done      = rnd(6);
         cmd_stop      = rnd(30);
         cmd_suspend   = rnd(30);
         evt_load      = rnd(6);
         evt_rx_store  = rnd(6);
         rx_frame_err  = rnd(12);
         rx_parity_err = rnd(12);
         bus_wr        = rnd(4);
         bus_rd        = rnd(6);
         ack_frame     = rnd(8);
         ack_parity    = rnd(8);
         ack_overrun   = rnd(8);
         tick();
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule